// File: doc/BRIEF.md
# Deep-Sleep Power-Well Handshake Sequencer

This block runs the entry and exit handshake between a platform hub and the power-management logic for the deepest standby state of a board. The hub signals that deep sleep is coming by pulling its active-low warning line low. The sequencer then waits for the dual 5 V rail to be reported low and acknowledges. After the hub asserts its active-low sleep line, the sequencer cuts both standby rails. On exit it turns the rails back on, holds the resume reset until the suspend rails report good, and finally waits for the hub to drop its warning.

While the rails are off, local wake sources can raise a wake request toward the hub. Each source has its own enable bit. Every wait step is guarded by one programmable cycle timeout. If a timeout expires, the sequencer falls back to the fully-on state and raises a sticky error flag. All hub and rail inputs are asynchronous and pass through a synchronizer of configurable depth.

Top module: `deep_sleep_seq`

## Requirements
- R1: After reset, ackN=1, stbyRailEnN=0 (rails on), resumeRstN=1, wakeReq=0 and errFlag=0.
- R2: After the hub pulls hubWarnN low, ackN stays 1 for as long as dualRailLow is 0. It goes to 0 only once dualRailLow=1 has been seen.
- R3: With ackN=0, hubSleepN=0 puts the block in deep sleep, giving stbyRailEnN=1 and resumeRstN=0. These values hold for as long as hubSleepN stays 0.
- R4: stbyRailEnN can go to 1 only after ackN is already 0.
- R5: When hubSleepN returns to 1, stbyRailEnN goes to 0 at once. resumeRstN stays 0 until susRailsUp=1 is seen, and then goes to 1.
- R6: After resumeRstN is released, ackN stays 0 until hubWarnN returns to 1. The block then goes idle with ackN=1.
- R7: If hubWarnN returns to 1 while the block is waiting for the dual rail or for the sleep assertion, it goes idle with ackN=1 and no error.
- R8: If the block stays in any of the four wait steps for timeoutCycles cycles, it goes idle and sets errFlag=1. The wait steps are: dual rail low, sleep assertion, rails up, and warning release. When timeoutCycles=0, no timeout occurs.
- R9: wakeSrc bit assignment: 0 LAN, 1 keyboard/mouse, 2 and 3 the two GPIO groups, 4 serial ring indicate, 5 RTC, 6 power button, 7 hub GPIO. In deep sleep, any source i with wakeSrc[i]=1 and wakeEnable[i]=1 sets wakeReq=1. wakeReq holds until hubSleepN returns to 1. Disabled sources, and sources that fire outside deep sleep, leave wakeReq at 0.
- R10: errFlag holds its value until the next entry begins, which is a new falling edge of hubWarnN seen while idle. That edge clears errFlag.
- R11: Every input passes through SYNC_STAGES flops. Its effect on an output appears exactly SYNC_STAGES+1 clock edges after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hubWarnN | input | 1 | Hub suspend warning, active low |
| hubSleepN | input | 1 | Hub suspend sleep, active low |
| dualRailLow | input | 1 | Dual 5 V rail below its threshold |
| susRailsUp | input | 1 | Suspend rails reported good |
| wakeSrc | input | NUM_WAKE | Wake event sources |
| wakeEnable | input | NUM_WAKE | Per-source wake enable, quasi-static |
| timeoutCycles | input | CNT_W | Wait-step timeout in cycles, 0 disables it |
| ackN | output | 1 | Suspend acknowledge, active low |
| stbyRailEnN | output | 1 | Standby rail enable, active low (1 = rails off) |
| resumeRstN | output | 1 | Resume reset, active low |
| wakeReq | output | 1 | Wake request toward the hub |
| errFlag | output | 1 | Sticky handshake timeout flag |

## Verification
A wrong internal state shows up at the outputs within one edge, because the outputs are decoded from the next state. Some wait steps drive exactly the same outputs as idle, so a state slip there shows only on the next step. The bench catches that as a latency mismatch of SYNC_STAGES+1 edges, or as an error flag rising one cycle early or late. A miscounted timeout or a wrongly masked wake source shows at errFlag or wakeReq on the exact expected edge.

// File: rtl/deep_sleep_pkg.sv
package deep_sleep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_WAIT_DUAL  = 3'd1,
    ST_ACKED      = 3'd2,
    ST_DEEP       = 3'd3,
    ST_WAIT_RAILS = 3'd4,
    ST_WAIT_WARN  = 3'd5
  } seqState_t;

  // synchronized observations from the datapath
  typedef struct packed {
    logic warnLow;
    logic warnFall;
    logic sleepLow;
    logic dualLow;
    logic railsUp;
    logic timedOut;
    logic wakeHit;
  } seqFlags_t;

  // control strobes toward the datapath
  typedef struct packed {
    logic cntClr;
    logic errSet;
    logic errClr;
    logic wakeArm;
    logic wakeClr;
  } seqStrobe_t;

endpackage

// File: rtl/deep_sleep_sync.sv
module deep_sleep_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int DEPTH = (STAGES < 1) ? 1 : STAGES;

  logic [WIDTH-1:0] chain [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < DEPTH; s++) chain[s] <= RESET_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < DEPTH; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[DEPTH-1];
endmodule

// File: rtl/deep_sleep_dp.sv
module deep_sleep_dp
  import deep_sleep_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W = 16,
  parameter int NUM_WAKE = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hubWarnN,
  input  logic                hubSleepN,
  input  logic                dualRailLow,
  input  logic                susRailsUp,
  input  logic [NUM_WAKE-1:0] wakeSrc,
  input  logic [NUM_WAKE-1:0] wakeEnable,
  input  logic [CNT_W-1:0]    timeoutCycles,
  input  seqStrobe_t          strobe,
  output seqFlags_t           flags,
  output logic                wakeReq,
  output logic                errFlag
);
  localparam int SYNC_W = 4 + NUM_WAKE;
  localparam logic [SYNC_W-1:0] SYNC_RST = {2'b11, 2'b00, {NUM_WAKE{1'b0}}};
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_W-1:0]   syncQ;
  logic                warnSyncN;
  logic                sleepSyncN;
  logic                dualSync;
  logic                railsSync;
  logic [NUM_WAKE-1:0] wakeSync;
  logic                warnPrevN;
  logic [CNT_W-1:0]    waitCnt;
  logic                limitOn;

  deep_sleep_sync #(
    .WIDTH(SYNC_W),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(SYNC_RST)
  ) inSync_i (
    .clk(clk),
    .rstN(rstN),
    .d({hubWarnN, hubSleepN, dualRailLow, susRailsUp, wakeSrc}),
    .q(syncQ)
  );

  assign {warnSyncN, sleepSyncN, dualSync, railsSync, wakeSync} = syncQ;

  // warning edge detect for a fresh entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warnPrevN <= 1'b1;
    else       warnPrevN <= warnSyncN;
  end

  // wait-step cycle counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 waitCnt <= '0;
    else if (strobe.cntClr)    waitCnt <= '0;
    else if (waitCnt != CNT_MAX) waitCnt <= waitCnt + CNT_W'(1);
  end

  assign limitOn = (timeoutCycles != '0);

  // wake request latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  wakeReq <= 1'b0;
    else if (strobe.wakeClr)                    wakeReq <= 1'b0;
    else if (strobe.wakeArm && flags.wakeHit)   wakeReq <= 1'b1;
  end

  // sticky timeout flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              errFlag <= 1'b0;
    else if (strobe.errClr) errFlag <= 1'b0;
    else if (strobe.errSet) errFlag <= 1'b1;
  end

  always_comb begin
    flags.warnLow  = ~warnSyncN;
    flags.warnFall = warnPrevN & ~warnSyncN;
    flags.sleepLow = ~sleepSyncN;
    flags.dualLow  = dualSync;
    flags.railsUp  = railsSync;
    flags.timedOut = limitOn && (waitCnt >= (timeoutCycles - CNT_W'(1)));
    flags.wakeHit  = |(wakeSync & wakeEnable);
  end

  assert_wake_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReq && !strobe.wakeClr) |=> wakeReq);

  assert_err_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !strobe.errClr) |=> errFlag);

endmodule

// File: rtl/deep_sleep_ctrl.sv
module deep_sleep_ctrl
  import deep_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqFlags_t  flags,
  input  logic       errFlag,
  input  logic       wakeReq,
  output seqStrobe_t strobe,
  output logic       ackN,
  output logic       stbyRailEnN,
  output logic       resumeRstN
);
  seqState_t state;
  seqState_t nextState;
  logic      timeoutTaken;
  logic      nAck;
  logic      nRailOff;
  logic      nRstLow;

  always_comb begin
    nextState    = state;
    timeoutTaken = 1'b0;
    case (state)
      ST_IDLE: begin
        if (flags.warnFall) nextState = ST_WAIT_DUAL;
      end
      ST_WAIT_DUAL: begin
        if (!flags.warnLow)      nextState = ST_IDLE;
        else if (flags.dualLow)  nextState = ST_ACKED;
        else if (flags.timedOut) begin
          nextState    = ST_IDLE;
          timeoutTaken = 1'b1;
        end
      end
      ST_ACKED: begin
        if (!flags.warnLow)      nextState = ST_IDLE;
        else if (flags.sleepLow) nextState = ST_DEEP;
        else if (flags.timedOut) begin
          nextState    = ST_IDLE;
          timeoutTaken = 1'b1;
        end
      end
      ST_DEEP: begin
        if (!flags.sleepLow) nextState = ST_WAIT_RAILS;
      end
      ST_WAIT_RAILS: begin
        if (flags.railsUp)       nextState = ST_WAIT_WARN;
        else if (flags.timedOut) begin
          nextState    = ST_IDLE;
          timeoutTaken = 1'b1;
        end
      end
      ST_WAIT_WARN: begin
        if (!flags.warnLow)      nextState = ST_IDLE;
        else if (flags.timedOut) begin
          nextState    = ST_IDLE;
          timeoutTaken = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.cntClr  = (nextState != state);
    strobe.errSet  = timeoutTaken;
    strobe.errClr  = (state == ST_IDLE) && flags.warnFall;
    strobe.wakeArm = (state == ST_DEEP);
    strobe.wakeClr = (state == ST_DEEP) && (nextState != ST_DEEP);
  end

  // output decode of the next state
  always_comb begin
    nAck     = 1'b0;
    nRailOff = 1'b0;
    nRstLow  = 1'b0;
    case (nextState)
      ST_ACKED:      nAck = 1'b1;
      ST_DEEP: begin
        nAck     = 1'b1;
        nRailOff = 1'b1;
        nRstLow  = 1'b1;
      end
      ST_WAIT_RAILS: begin
        nAck    = 1'b1;
        nRstLow = 1'b1;
      end
      ST_WAIT_WARN:  nAck = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      ackN        <= 1'b1;
      stbyRailEnN <= 1'b0;
      resumeRstN  <= 1'b1;
    end else begin
      state       <= nextState;
      ackN        <= ~nAck;
      stbyRailEnN <= nRailOff;
      resumeRstN  <= ~nRstLow;
    end
  end

  assert_ack_after_dual_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackN) |-> $past(flags.dualLow));

  assert_rail_cut_after_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stbyRailEnN) |-> ($past(!ackN) && $past(flags.sleepLow)));

  assert_reset_after_rails_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resumeRstN) |-> ($past(flags.railsUp) || errFlag));

  assert_err_lands_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> (ackN && !stbyRailEnN && resumeRstN));

  assert_wake_only_asleep_R9: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> stbyRailEnN);

endmodule

// File: rtl/deep_sleep_seq.sv
module deep_sleep_seq
  import deep_sleep_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W = 16,
  parameter int NUM_WAKE = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hubWarnN,
  input  logic                hubSleepN,
  input  logic                dualRailLow,
  input  logic                susRailsUp,
  input  logic [NUM_WAKE-1:0] wakeSrc,
  input  logic [NUM_WAKE-1:0] wakeEnable,
  input  logic [CNT_W-1:0]    timeoutCycles,
  output logic                ackN,
  output logic                stbyRailEnN,
  output logic                resumeRstN,
  output logic                wakeReq,
  output logic                errFlag
);
  seqFlags_t  flags;
  seqStrobe_t strobe;

  deep_sleep_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W(CNT_W),
    .NUM_WAKE(NUM_WAKE)
  ) dp_i (
    .clk(clk),
    .rstN(rstN),
    .hubWarnN(hubWarnN),
    .hubSleepN(hubSleepN),
    .dualRailLow(dualRailLow),
    .susRailsUp(susRailsUp),
    .wakeSrc(wakeSrc),
    .wakeEnable(wakeEnable),
    .timeoutCycles(timeoutCycles),
    .strobe(strobe),
    .flags(flags),
    .wakeReq(wakeReq),
    .errFlag(errFlag)
  );

  deep_sleep_ctrl ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .flags(flags),
    .errFlag(errFlag),
    .wakeReq(wakeReq),
    .strobe(strobe),
    .ackN(ackN),
    .stbyRailEnN(stbyRailEnN),
    .resumeRstN(resumeRstN)
  );
endmodule

// File: tb/deep_sleep_seq_tb_top.sv
module deep_sleep_seq_tb_top;
  localparam int SYNC_STAGES = 2;
  localparam int CNT_W = 8;
  localparam int NUM_WAKE = 8;
  localparam int LAT = SYNC_STAGES + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hubWarnN = 1'b1;
  logic hubSleepN = 1'b1;
  logic dualRailLow = 1'b0;
  logic susRailsUp = 1'b0;
  logic [NUM_WAKE-1:0] wakeSrc = '0;
  logic [NUM_WAKE-1:0] wakeEnable = '1;
  logic [CNT_W-1:0] timeoutCycles = '0;
  logic ackN, stbyRailEnN, resumeRstN, wakeReq, errFlag;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  deep_sleep_seq #(
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W(CNT_W),
    .NUM_WAKE(NUM_WAKE)
  ) dut_i (
    .clk(clk), .rstN(rstN), .hubWarnN(hubWarnN), .hubSleepN(hubSleepN),
    .dualRailLow(dualRailLow), .susRailsUp(susRailsUp), .wakeSrc(wakeSrc),
    .wakeEnable(wakeEnable), .timeoutCycles(timeoutCycles), .ackN(ackN),
    .stbyRailEnN(stbyRailEnN), .resumeRstN(resumeRstN), .wakeReq(wakeReq),
    .errFlag(errFlag)
  );

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chkOut(input string req, input int eAck, input int eRail, input int eRst);
    chk(req, "ackN", int'(ackN), eAck);
    chk(req, "stbyRailEnN", int'(stbyRailEnN), eRail);
    chk(req, "resumeRstN", int'(resumeRstN), eRst);
  endtask

  task automatic goIdle();
    hubWarnN = 1'b1; hubSleepN = 1'b1; dualRailLow = 1'b0; susRailsUp = 1'b0;
    wakeSrc = '0; timeoutCycles = '0;
    tick(LAT + 2);
  endtask

  task automatic enterDeep();
    hubWarnN = 1'b0; dualRailLow = 1'b1;
    tick(LAT + 2);
    hubSleepN = 1'b0;
    tick(LAT + 1);
  endtask

  task automatic runTimeout(input int stage, input int lim);
    goIdle();
    case (stage)
      0: begin
        hubWarnN = 1'b0;
      end
      1: begin
        hubWarnN = 1'b0;
        tick(LAT + 1);
        dualRailLow = 1'b1;
      end
      2: begin
        enterDeep();
        hubSleepN = 1'b1;
      end
      default: begin
        enterDeep();
        hubSleepN = 1'b1;
        tick(LAT + 1);
        susRailsUp = 1'b1;
      end
    endcase
    tick(LAT - 1);
    timeoutCycles = CNT_W'(lim);
    tick(lim);
    chk("R8", $sformatf("err before expiry st%0d lim%0d", stage, lim), int'(errFlag), 0);
    tick(1);
    chk("R8", $sformatf("err at expiry st%0d lim%0d", stage, lim), int'(errFlag), 1);
    chkOut("R8", 1, 0, 1);
    goIdle();
    chk("R10", "err held after inputs idle", int'(errFlag), 1);
    hubWarnN = 1'b0;
    tick(LAT - 1);
    chk("R10", "err before entry edge", int'(errFlag), 1);
    tick(1);
    chk("R10", "err cleared by new entry", int'(errFlag), 0);
    goIdle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failed++;
      total++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    // R1 reset state
    chkOut("R1", 1, 0, 1);
    chk("R1", "wakeReq", int'(wakeReq), 0);
    chk("R1", "errFlag", int'(errFlag), 0);

    // full handshake, timeout disabled
    hubWarnN = 1'b0;
    tick(LAT + 20);
    chk("R2", "ack held without dual low", int'(ackN), 1);
    chk("R8", "no timeout when limit 0", int'(errFlag), 0);
    dualRailLow = 1'b1;
    tick(LAT - 1);
    chk("R11", "ack before latency", int'(ackN), 1);
    tick(1);
    chk("R2", "ack after dual low", int'(ackN), 0);
    chk("R11", "rails on while acked", int'(stbyRailEnN), 0);
    hubSleepN = 1'b0;
    tick(LAT - 1);
    chk("R4", "rails still on", int'(stbyRailEnN), 0);
    tick(1);
    chkOut("R3", 0, 1, 0);
    tick(15);
    chkOut("R3", 0, 1, 0);
    hubSleepN = 1'b1;
    tick(LAT - 1);
    chk("R11", "rails off before latency", int'(stbyRailEnN), 1);
    tick(1);
    chkOut("R5", 0, 0, 0);
    tick(12);
    chk("R5", "reset held until rails up", int'(resumeRstN), 0);
    susRailsUp = 1'b1;
    tick(LAT);
    chkOut("R5", 0, 0, 1);
    tick(12);
    chk("R6", "ack held until warn release", int'(ackN), 0);
    hubWarnN = 1'b1; dualRailLow = 1'b0;
    tick(LAT);
    chkOut("R6", 1, 0, 1);
    chk("R6", "no error", int'(errFlag), 0);
    goIdle();

    // R7 abort while waiting for dual
    hubWarnN = 1'b0;
    tick(LAT + 3);
    hubWarnN = 1'b1;
    tick(LAT + 2);
    dualRailLow = 1'b1;
    tick(LAT + 2);
    chk("R7", "no ack after abort from dual wait", int'(ackN), 1);
    chk("R7", "no error after abort", int'(errFlag), 0);
    goIdle();
    // R7 abort while acked
    hubWarnN = 1'b0; dualRailLow = 1'b1;
    tick(LAT + 2);
    chk("R7", "acked", int'(ackN), 0);
    hubWarnN = 1'b1;
    tick(LAT);
    chkOut("R7", 1, 0, 1);
    chk("R7", "no error after ack abort", int'(errFlag), 0);
    goIdle();

    // R8 timeout sweep over all wait steps
    for (int st = 0; st < 4; st++) begin
      for (int lim = 1; lim <= 5; lim++) runTimeout(st, lim);
    end

    // R9 wake sweep over every source
    for (int i = 0; i < NUM_WAKE; i++) begin
      wakeEnable = '1;
      wakeSrc = NUM_WAKE'(1) << i;
      tick(LAT + 2);
      chk("R9", $sformatf("src%0d ignored while on", i), int'(wakeReq), 0);
      wakeSrc = '0;
      tick(LAT);
      enterDeep();
      chk("R9", $sformatf("src%0d in deep sleep", i), int'(stbyRailEnN), 1);
      wakeEnable = ~(NUM_WAKE'(1) << i);
      wakeSrc = NUM_WAKE'(1) << i;
      tick(LAT + 2);
      chk("R9", $sformatf("src%0d masked", i), int'(wakeReq), 0);
      wakeSrc = '0;
      tick(LAT);
      wakeEnable = NUM_WAKE'(1) << i;
      wakeSrc = NUM_WAKE'(1) << i;
      tick(LAT - 1);
      chk("R11", $sformatf("src%0d wake before latency", i), int'(wakeReq), 0);
      tick(1);
      chk("R9", $sformatf("src%0d wake raised", i), int'(wakeReq), 1);
      wakeSrc = '0;
      tick(10);
      chk("R9", $sformatf("src%0d wake held", i), int'(wakeReq), 1);
      hubSleepN = 1'b1;
      tick(LAT - 1);
      chk("R9", $sformatf("src%0d wake held to exit", i), int'(wakeReq), 1);
      tick(1);
      chk("R9", $sformatf("src%0d wake cleared on exit", i), int'(wakeReq), 0);
      susRailsUp = 1'b1;
      tick(LAT + 1);
      goIdle();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule